// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block decides which source drives the system clock: the slow sub-clock, the main oscillator clock, or the PLL-multiplied clock. It also brings the system back out of a PLL-stop low-power state. When a mode change is accepted, the sequencer turns on the oscillator and PLL enables that the new source needs. It then counts a stabilization wait in ticks of the oscillation clock. During that wait the current source stays selected. Only when the count runs out does the new source get selected and the two status flags get updated. Enables that the new source does not need are dropped at that same moment.

The length of the wait depends on the starting point. A move from the main clock to the PLL uses a fixed lock time. A move away from the sub-clock, or out of PLL-stop, restarts the stopped oscillator and the PLL together under one shared count, chosen by a 2-bit wait-select field. When such a move ends on the PLL, a code shorter than the lock time is raised to the lock time. Moves toward a clock that is already running finish after a single tick. Any request that arrives while a switch is in flight is dropped, and so is any request for a move the block does not support.

Top module: `clksw_seq`

## Requirements
- R1: After reset: `src_sel`=00 (main clock), `main_osc_en`=1, `pll_en`=0, `stat_pll`=0, `stat_sub`=0 and `busy`=0. The `req_mode` encoding is 00 main, 01 PLL, 10 sub-clock, 11 PLL-stop, and `src_sel` uses the same encoding.
- R2: A main-to-PLL request raises `pll_en` on the accepting edge. It completes after exactly 2^PLL_LOCK_LOG2 oscillation ticks, whatever the value of `ws_code`. While `src_sel` is 01, both enables are high.
- R3: While `busy` is high, `src_sel` keeps the old source. It changes only on the edge where `busy` falls.
- R4: A request for the PLL from the sub-clock or from PLL-stop raises both `main_osc_en` and `pll_en` on the accepting edge. It waits one shared count of 2^(WAIT_BASE_LOG2 + code*WAIT_STEP_LOG2) ticks, where code = `ws_code`.
- R5: On a PLL-bound move from the sub-clock or from PLL-stop, a wait-select code whose length is below 2^PLL_LOCK_LOG2 is treated as 2^PLL_LOCK_LOG2.
- R6: A request for the main clock from the sub-clock raises `main_osc_en` and waits the count selected by `ws_code`, with no minimum applied.
- R7: A request for the sub-clock from the main clock or from the PLL completes after one tick. At completion `main_osc_en` and `pll_en` are both 0.
- R8: A PLL-to-main request completes after one tick and clears `pll_en`. A PLL-to-PLL-stop request completes after one tick with `src_sel`=11 and both enables at 0.
- R9: `stat_pll` (1 for PLL or PLL-stop) and `stat_sub` (1 for sub-clock) change only on the edge where `busy` falls.
- R10: A request made while `busy` is high has no effect on the switch in flight: its duration and its final source are unchanged.
- R11: A request that matches the current mode, or that asks for an unsupported move (PLL-stop from main or sub-clock; main or sub-clock from PLL-stop), is dropped: `busy` stays 0 and the outputs do not change.
- R12: The wait counts only cycles with `osc_tick`=1. Cycles without a tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle tick of the oscillation clock that advances the wait count |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode (00 main, 01 PLL, 10 sub, 11 PLL-stop) |
| ws_code | input | 2 | Wait-select code for moves that restart oscillators |
| src_sel | output | 2 | Clock source currently in use (11 = stopped) |
| main_osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| stat_pll | output | 1 | Status flag: PLL path selected (PLL or PLL-stop) |
| stat_sub | output | 1 | Status flag: sub-clock selected |
| busy | output | 1 | High from acceptance of a switch until its completion |

## Verification
The bench uses a small configuration: wait lengths of 4, 8, 16 and 32, and a PLL lock time of 16. It sweeps all four wait codes over three kinds of move: sub-clock to main, sub-clock to PLL, and PLL-stop to PLL. Measuring the length of each wait separates the path where the code is used directly from the path where the lock-time minimum raises it. The fixed main-to-PLL path is tried with the shortest and the longest code, to show that the code is ignored there. A sparse tick pattern separates counting ticks from counting cycles. The bench also sends requests during a wait, and requests for the same mode or unsupported moves, and checks that the outputs do not change.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2,
        SRC_STOP = 2'd3
    } src_t;

    typedef struct packed {
        logic take;
        src_t tgt;
        logic on_main;
        logic on_pll;
        logic fin_main;
        logic fin_pll;
    } plan_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clksw_plan.sv
module clksw_plan
    import clksw_pkg::*;
#(
    parameter int BASE_LOG2 = 10,
    parameter int STEP_LOG2 = 2,
    parameter int LOCK_LOG2 = 14,
    parameter int CW        = 17
) (
    input  src_t          cur,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic [1:0]    ws_code,
    output plan_t         plan,
    output logic [CW-1:0] wait_val
);

    int   sel_log2;
    int   pll_log2;
    src_t req;

    always_comb begin
        sel_log2 = BASE_LOG2 + int'(ws_code) * STEP_LOG2;
        pll_log2 = imax(sel_log2, LOCK_LOG2);
        req      = src_t'(req_mode);

        plan          = '0;
        plan.tgt      = req;
        plan.fin_main = (req == SRC_MAIN) || (req == SRC_PLL);
        plan.fin_pll  = (req == SRC_PLL);
        plan.on_main  = plan.fin_main;
        plan.on_pll   = plan.fin_pll;
        wait_val      = CW'(1);

        unique case (cur)
            SRC_MAIN: begin
                if (req == SRC_PLL) begin
                    plan.take = 1'b1;
                    wait_val  = CW'(1) << LOCK_LOG2;
                end else if (req == SRC_SUB) begin
                    plan.take = 1'b1;
                end
            end
            SRC_PLL: begin
                plan.take = (req != SRC_PLL);
            end
            SRC_SUB: begin
                if (req == SRC_MAIN) begin
                    plan.take = 1'b1;
                    wait_val  = CW'(1) << sel_log2;
                end else if (req == SRC_PLL) begin
                    plan.take = 1'b1;
                    wait_val  = CW'(1) << pll_log2;
                end
            end
            SRC_STOP: begin
                if (req == SRC_PLL) begin
                    plan.take = 1'b1;
                    wait_val  = CW'(1) << pll_log2;
                end
            end
            default: plan.take = 1'b0;
        endcase

        if (!req_valid) plan.take = 1'b0;
    end

endmodule

// File: rtl/clksw_wait_ctr.sv
module clksw_wait_ctr #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          done
);

    logic [CW-1:0] cnt;

    assign done = !load && tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= {1'b1, {(CW-1){1'b0}}}); // R4
    AST_CNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt)); // R12

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int WAIT_BASE_LOG2 = 10,
    parameter int WAIT_STEP_LOG2 = 2,
    parameter int PLL_LOCK_LOG2  = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic [1:0] ws_code,
    output logic [1:0] src_sel,
    output logic       main_osc_en,
    output logic       pll_en,
    output logic       stat_pll,
    output logic       stat_sub,
    output logic       busy
);

    localparam int SEL_MAX_LOG2 = WAIT_BASE_LOG2 + 3 * WAIT_STEP_LOG2;
    localparam int MAX_LOG2     = (SEL_MAX_LOG2 > PLL_LOCK_LOG2) ? SEL_MAX_LOG2 : PLL_LOCK_LOG2;
    localparam int CW           = MAX_LOG2 + 1;

    src_t          cur;
    src_t          tgt;
    plan_t         plan;
    logic [CW-1:0] wait_val;
    logic          load;
    logic          done;
    logic          fin_main;
    logic          fin_pll;

    clksw_plan #(
        .BASE_LOG2 (WAIT_BASE_LOG2),
        .STEP_LOG2 (WAIT_STEP_LOG2),
        .LOCK_LOG2 (PLL_LOCK_LOG2),
        .CW        (CW)
    ) u_plan (
        .cur       (cur),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .ws_code   (ws_code),
        .plan      (plan),
        .wait_val  (wait_val)
    );

    assign load = !busy && plan.take;

    clksw_wait_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (wait_val),
        .tick     (osc_tick),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= SRC_MAIN;
            tgt         <= SRC_MAIN;
            busy        <= 1'b0;
            main_osc_en <= 1'b1;
            pll_en      <= 1'b0;
            fin_main    <= 1'b1;
            fin_pll     <= 1'b0;
            stat_pll    <= 1'b0;
            stat_sub    <= 1'b0;
        end else if (load) begin
            busy        <= 1'b1;
            tgt         <= plan.tgt;
            fin_main    <= plan.fin_main;
            fin_pll     <= plan.fin_pll;
            main_osc_en <= main_osc_en | plan.on_main;
            pll_en      <= pll_en | plan.on_pll;
        end else if (busy && done) begin
            busy        <= 1'b0;
            cur         <= tgt;
            main_osc_en <= fin_main;
            pll_en      <= fin_pll;
            stat_pll    <= (tgt == SRC_PLL) || (tgt == SRC_STOP);
            stat_sub    <= (tgt == SRC_SUB);
        end
    end

    assign src_sel = cur;

    AST_SEL_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(src_sel)); // R3
    AST_PLL_HAS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_PLL) |-> (main_osc_en && pll_en)); // R2
    AST_SUB_QUIET: assert property (@(posedge clk) disable iff (rst)
        (stat_sub && !busy) |-> (!main_osc_en && !pll_en)); // R7
    AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (rst)
        (!$stable(stat_pll) || !$stable(stat_sub)) |-> $fell(busy)); // R9
    AST_NO_RETAKE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tgt)); // R10
    AST_PLL_MIN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (load && plan.tgt == SRC_PLL && cur != SRC_MAIN)
            |-> (wait_val >= (CW'(1) << PLL_LOCK_LOG2))); // R5

endmodule

// File: tb/clksw_seq_test.sv
`timescale 1ns/1ps
module clksw_seq_test;

    localparam int BASE = 2;
    localparam int STEP = 1;
    localparam int LOCK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [1:0] ws_code = 2'd0;
    logic [1:0] src_sel;
    logic       main_osc_en, pll_en, stat_pll, stat_sub, busy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    clksw_seq #(
        .WAIT_BASE_LOG2 (BASE),
        .WAIT_STEP_LOG2 (STEP),
        .PLL_LOCK_LOG2  (LOCK)
    ) uut (
        .clk, .rst, .osc_tick, .req_valid, .req_mode, .ws_code,
        .src_sel, .main_osc_en, .pll_en, .stat_pll, .stat_sub, .busy
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sel_len(input int c);
        return 1 << (BASE + c * STEP);
    endfunction

    function automatic int pll_len(input int c);
        int l = sel_len(c);
        return (l < (1 << LOCK)) ? (1 << LOCK) : l;
    endfunction

    task automatic chk_state(input logic [1:0] m, input string req);
        chk(src_sel == m, req, src_sel, m);
        chk(main_osc_en == (m == 2'd0 || m == 2'd1), req, main_osc_en, (m == 2'd0 || m == 2'd1));
        chk(pll_en == (m == 2'd1), req, pll_en, (m == 2'd1));
        chk(stat_pll == (m == 2'd1 || m == 2'd3), req, stat_pll, (m == 2'd1 || m == 2'd3));
        chk(stat_sub == (m == 2'd2), req, stat_sub, (m == 2'd2));
    endtask

    task automatic do_sw(input logic [1:0] m, input logic [1:0] c, input int exp_len,
                         input int tper, input bit inject, input string req);
        logic [1:0] old_sel = src_sel;
        logic       old_p   = stat_pll;
        logic       old_s   = stat_sub;
        int n = 0;
        int k = 0;
        bit held = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; ws_code = c; osc_tick = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, req, busy, 1);
        if (m == 2'd1) chk(main_osc_en && pll_en, "R4", {main_osc_en, pll_en}, 3);
        if (m == 2'd0 && old_sel == 2'd2) chk(main_osc_en == 1'b1, "R6", main_osc_en, 1);
        while (busy && k < 5000) begin
            if (src_sel != old_sel || stat_pll != old_p || stat_sub != old_s) held = 1'b0;
            req_valid = inject && (k == 3);
            req_mode  = (old_sel == 2'd2) ? 2'd1 : 2'd2;
            osc_tick  = ((k % tper) == 0);
            if (osc_tick) n++;
            k++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        osc_tick  = 1'b1;
        chk(n == exp_len, req, n, exp_len);
        chk(held, "R3", held, 1);
        chk_state(m, req);
    endtask

    task automatic no_take(input logic [1:0] m, input string req);
        logic [1:0] old_sel = src_sel;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b0, req, busy, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && src_sel == old_sel, req, src_sel, old_sel);
        chk_state(old_sel, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", busy, 0);
        chk_state(2'd0, "R1");

        no_take(2'd0, "R11");
        no_take(2'd3, "R11");

        do_sw(2'd1, 2'd0, 1 << LOCK, 1, 1'b0, "R2");
        do_sw(2'd0, 2'd0, 1, 1, 1'b0, "R8");
        do_sw(2'd1, 2'd3, 1 << LOCK, 3, 1'b0, "R12");
        no_take(2'd1, "R11");
        do_sw(2'd2, 2'd0, 1, 1, 1'b0, "R7");

        for (int c = 0; c < 4; c++) begin
            do_sw(2'd0, 2'(c), sel_len(c), 1, 1'b0, "R6");
            do_sw(2'd2, 2'(c), 1, 1, 1'b0, "R7");
        end
        no_take(2'd3, "R11");
        no_take(2'd2, "R11");

        for (int c = 0; c < 4; c++) begin
            do_sw(2'd1, 2'(c), pll_len(c), 1, 1'b0, (c < 2) ? "R5" : "R4");
            do_sw(2'd2, 2'(c), 1, 1, 1'b0, "R7");
        end

        do_sw(2'd1, 2'd2, pll_len(2), 1, 1'b0, "R4");
        for (int c = 0; c < 4; c++) begin
            do_sw(2'd3, 2'(c), 1, 1, 1'b0, "R8");
            no_take(2'd0, "R11");
            do_sw(2'd1, 2'(c), pll_len(c), 1, 1'b0, (c < 2) ? "R5" : "R4");
        end

        do_sw(2'd0, 2'd0, 1, 1, 1'b0, "R8");
        do_sw(2'd1, 2'd1, 1 << LOCK, 1, 1'b1, "R10");
        do_sw(2'd2, 2'd0, 1, 1, 1'b0, "R7");
        do_sw(2'd1, 2'd3, pll_len(3), 2, 1'b1, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule